// File: doc/BRIEF.md
# Wired-AND SCL Clock Generator

This block produces the serial clock of one bus master on a clock line shared in open-drain fashion with other masters and with slaves. It never drives the line high. It only asserts a pull-low enable, and it watches the real line level through a synchronizer. Its LOW time is counted from the falling edge it actually observes on the line, whoever caused that edge. After its LOW count it lets go of the line and waits until the line is really high. Its HIGH time is counted from that observed rising edge. If any other participant pulls the line low during the HIGH count, the block drops the count and starts a new LOW period at once.

The bus clock that results has the longest LOW time and the shortest HIGH time of all the devices taking part. A slow slave can stretch any LOW phase simply by holding the line. A data engine next to this block gets single-cycle strobes that mark each observed rising and falling edge of the line. It uses them to place and sample bits.

Top module: `scl_sync_gen`

## Requirements
- R1: While `rst_n` is low, `scl_drive_low`, `rise_stb` and `fall_stb` are all 0.
- R2: The line input passes through SYNC_STAGES (default 2) flops. A change of `scl_in` presented just after clock edge X gives a one-cycle `rise_stb` (low to high) or `fall_stb` (high to low) during the cycle after edge X+2. The two strobes are never high together, and neither stays high for two cycles in a row.
- R3: When no other device holds the line, each bus LOW phase lasts max(low_cnt,1)+3 clock cycles, counted from the cycle in which the line goes low.
- R4: When no other device pulls the line low early, each bus HIGH phase lasts max(high_cnt,1)+3 clock cycles.
- R5: A count of 0 on `low_cnt` or `high_cnt` behaves exactly like a count of 1.
- R6: If another device keeps the line low past the block's own LOW count, the block releases the line and waits. Its HIGH count starts only after the line is seen high, so that LOW phase lasts as long as the other device holds the line.
- R7: A falling edge seen while the HIGH count is running aborts the count. The block then pulls the line low and counts a full LOW period from that edge, so that LOW phase lasts max(low_cnt,1)+3 cycles from the line falling.
- R8: While `en` is low, in that same cycle, `scl_drive_low` is 0 and no strobe is emitted, whatever the line does. Raising `en` makes the block pull the line low on the next clock edge.
- R9: When combined with another master, the bus LOW phase equals the longer of the two LOW times, and the bus HIGH phase equals the shorter of the two HIGH times. This includes the case where both masters end their HIGH time in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable for clock generation |
| low_cnt | input | CNT_W | LOW period in clock cycles |
| high_cnt | input | CNT_W | HIGH period in clock cycles |
| scl_in | input | 1 | Sampled level of the shared clock line |
| scl_drive_low | output | 1 | Pull-low enable for the open-drain clock pad |
| rise_stb | output | 1 | One-cycle strobe on an observed line rising edge |
| fall_stb | output | 1 | One-cycle strobe on an observed line falling edge |

## Verification
Two events can fall in the same cycle: the block's own HIGH count expires and a foreign falling edge arrives. The bench sets up an emulated second master whose HIGH time is exactly max(high_cnt,1)+3. The block's pull-low and the foreign pull-low therefore land in the same cycle, and the next LOW phase must still last exactly max(low_cnt,1)+3 cycles from the line falling. The scoreboard judges every bus phase by its measured length against the longest-LOW and shortest-HIGH rule. Every strobe is judged against the line history two samples back.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phases of the clock generator
    typedef enum logic [2:0] {
        PH_OFF,    // disabled, line released
        PH_PULL,   // pulling low, waiting to see the line low
        PH_LOW,    // pulling low, counting LOW period
        PH_HWAIT,  // released, waiting to see the line high
        PH_HIGH    // released, counting HIGH period
    } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t reg_d, reg_q;

    always_comb begin
        reg_d          = reg_q;
        reg_d.chain[0] = line_i;
        for (int i = 1; i < STAGES; i++) begin
            reg_d.chain[i] = reg_q.chain[i-1];
        end
        reg_d.prev = reg_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign level_o = reg_q.chain[STAGES-1];
    assign rise_o  = reg_q.chain[STAGES-1] & ~reg_q.prev;
    assign fall_o  = ~reg_q.chain[STAGES-1] & reg_q.prev;

endmodule

// File: rtl/scl_period_cnt.sv
module scl_period_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // one cycle left (or zero loaded): period ends at the next edge
    assign done_o = (cnt_q <= W'(1));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         level_i,
    input  logic         fall_i,
    input  logic         done_i,
    input  logic [W-1:0] low_i,
    input  logic [W-1:0] high_i,
    output logic         load_o,
    output logic [W-1:0] load_val_o,
    output logic         drive_o,
    output logic         active_o
);

    typedef struct packed {
        phase_e phase;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        load_o     = 1'b0;
        load_val_o = low_i;
        if (!en_i) begin
            st_d.phase = PH_OFF;
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = PH_PULL;
                end
                PH_PULL: begin
                    if (!level_i) begin
                        st_d.phase = PH_LOW;
                        load_o     = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (done_i) begin
                        st_d.phase = PH_HWAIT;
                    end
                end
                PH_HWAIT: begin
                    if (level_i) begin
                        st_d.phase = PH_HIGH;
                        load_o     = 1'b1;
                        load_val_o = high_i;
                    end
                end
                PH_HIGH: begin
                    if (fall_i) begin
                        // another device ended the HIGH time first
                        st_d.phase = PH_LOW;
                        load_o     = 1'b1;
                    end else if (done_i) begin
                        st_d.phase = PH_PULL;
                    end
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_o  = (st_q.phase == PH_PULL) || (st_q.phase == PH_LOW);
    assign active_o = (st_q.phase != PH_OFF);

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic             lvl, rise_e, fall_e;
    logic             cnt_done, cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             drive_req, active;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (scl_in),
        .level_o (lvl),
        .rise_o  (rise_e),
        .fall_o  (fall_e)
    );

    scl_period_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .done_o (cnt_done)
    );

    scl_phase_fsm #(.W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .level_i    (lvl),
        .fall_i     (fall_e),
        .done_i     (cnt_done),
        .low_i      (low_cnt),
        .high_i     (high_cnt),
        .load_o     (cnt_load),
        .load_val_o (cnt_val),
        .drive_o    (drive_req),
        .active_o   (active)
    );

    assign scl_drive_low = en & drive_req;
    assign rise_stb      = en & active & rise_e;
    assign fall_stb      = en & active & fall_e;

endmodule

// File: rtl/scl_sync_gen_chk.sv
module scl_sync_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_drive_low,
    input logic rise_stb,
    input logic fall_stb
);

    a_r8_release_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !scl_drive_low);

    a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!rise_stb && !fall_stb));

    a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);

    // R3: once pulling, the block holds the line at least one more cycle
    a_r3_pull_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |=> (scl_drive_low || !en));

endmodule

bind scl_sync_gen scl_sync_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .scl_drive_low (scl_drive_low),
    .rise_stb      (rise_stb),
    .fall_stb      (fall_stb)
);

// File: tb/sim_scl_sync_gen.sv
`timescale 1ns/100ps
module sim_scl_sync_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] low_cnt = '0;
    logic [15:0] high_cnt = '0;
    logic        other_low = 1'b0;
    logic        man_other = 1'b0;
    logic        agent_on = 1'b0;
    logic        armed = 1'b0;
    logic        chk_off = 1'b0;
    int          cfg_s = 0;
    int          cfg_k = 0;
    logic        drv, rise, fall;
    logic        line;

    assign line = ~(drv | other_low);

    always #2.5 clk = ~clk;

    scl_sync_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .low_cnt       (low_cnt),
        .high_cnt      (high_cnt),
        .scl_in        (line),
        .scl_drive_low (drv),
        .rise_stb      (rise),
        .fall_stb      (fall)
    );

    int   checks = 0;
    int   fails = 0;
    int   exp_q[$];
    logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1, en_p = 1'b0;
    logic cur_lvl = 1'b1;
    logic ph_armed = 1'b0;
    int   plen = 0;

    task automatic chk(input bit ok, input string req, input int got, input int want);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d", req, got, want);
        end
    endtask

    // monitor: strobes against line history, phases against the queue
    always @(negedge clk) begin : mon
        logic er, ef;
        int   e;
        if (rst_n) begin
            er = en && en_p && h2 && !h3;   // R2 rise two samples back
            ef = en && en_p && !h2 && h3;   // R2 fall two samples back
            if (er || rise) chk(rise == er, "R2 rise strobe", int'(rise), int'(er));
            if (ef || fall) chk(fall == ef, "R2 fall strobe", int'(fall), int'(ef));
            if (chk_off) begin
                chk(!drv && !rise && !fall, "R8 disabled outputs",
                    int'({drv, rise, fall}), 0);
            end else if (!en && drv) begin
                chk(1'b0, "R8 drive while disabled", int'(drv), 0);
            end
            if (line == cur_lvl) begin
                plen++;
            end else begin
                if (ph_armed && armed && exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    chk((plen * 2 + int'(cur_lvl)) == e / 16,
                        $sformatf("R%0d phase lvl=%0d", e % 16, cur_lvl),
                        plen, (e / 16) / 2);
                end
                cur_lvl  = line;
                plen     = 1;
                ph_armed = armed;
            end
            h3   = h2;
            h2   = h1;
            h1   = line;
            en_p = en;
        end
    end

    // emulated second device: holds LOW for cfg_s samples, ends HIGH after cfg_k samples
    always @(posedge clk) begin
        #0.6;
        if (!agent_on) begin
            other_low = man_other;
        end else if (!ph_armed) begin
            other_low = 1'b0;
        end else if (!cur_lvl) begin
            other_low = (cfg_s != 0) && (plen < cfg_s);
        end else begin
            other_low = (cfg_k != 0) && (plen >= cfg_k);
        end
    end

    // driver: configure, push expected phases, wait for them to be consumed
    task automatic run_cfg(input int l, input int h, input int s, input int k,
                           input int n, input int rl, input int rh);
        int lp, hp, le, he;
        lp = (l == 0) ? 1 : l;
        hp = (h == 0) ? 1 : h;
        le = (lp + 3 > s) ? lp + 3 : s;
        he = (k != 0 && k < hp + 3) ? k : hp + 3;
        @(posedge clk); #0.2;
        low_cnt  = 16'(l);
        high_cnt = 16'(h);
        cfg_s    = s;
        cfg_k    = k;
        for (int i = 0; i < n; i++) begin
            if (i % 2 == 0) exp_q.push_back((le * 2 + 0) * 16 + rl);
            else            exp_q.push_back((he * 2 + 1) * 16 + rh);
        end
        armed    = 1'b1;
        agent_on = 1'b1;
        en       = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(posedge clk); #0.2;
        armed    = 1'b0;
        agent_on = 1'b0;
        en       = 1'b0;
        repeat (12) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired got=%0d exp=%0d", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!drv && !rise && !fall, "R1 reset outputs", int'({drv, rise, fall}), 0);
        @(posedge clk); #0.2;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!drv && line, "R1 idle after reset", int'({drv, line}), 1);

        // R8: disabled block ignores line activity
        @(posedge clk); #0.2;
        chk_off = 1'b1;
        for (int i = 0; i < 4; i++) begin
            repeat (3) @(posedge clk);
            #0.2 man_other = ~man_other;
        end
        @(posedge clk); #0.2 man_other = 1'b0;
        repeat (6) @(posedge clk);
        #0.2 chk_off = 1'b0;

        // R3, R4: free running
        run_cfg(5, 7, 0, 0, 6, 3, 4);
        run_cfg(1, 2, 0, 0, 4, 3, 4);
        // R5: zero counts act as one
        run_cfg(0, 0, 0, 0, 4, 5, 5);
        // R6: stretched LOW by a slow device
        run_cfg(5, 3, 20, 0, 4, 6, 4);
        // R7: foreign falling edge cuts the HIGH count
        run_cfg(6, 10, 4, 5, 4, 7, 7);
        // R9: longest LOW and shortest HIGH both from the other master
        run_cfg(3, 12, 15, 6, 4, 9, 9);
        // R9: both masters end HIGH in the same cycle
        run_cfg(2, 4, 4, 7, 4, 9, 9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule